// File: doc/BRIEF.md
# SRAM Access Strobe Sequencer

This block sequences the control strobes for one word-wide SRAM block of 64 rows. It accepts one read or one write request at a time and steps through a fixed order of phases. Each phase lasts a set number of ticks of a fast timing clock. From the current phase it drives these strobes: bitline precharge, write-driver enable, row-decoder enable (which also gates the wordline), sense-amplifier enable and an output-register capture strobe. It also reports busy, a done pulse on the last tick of each operation, and an error pulse for a request it cannot serve.

Reads and writes do not follow the same order. A write drops precharge at once and drives the bitlines for a lead phase. It then opens the wordline while still driving, and ends with a long recovery precharge. A read first precharges, then opens the wordline and turns on the sense amplifier part-way through the access window. One tick after the wordline closes it captures the sensed word, and only then starts a shorter recovery precharge. Every phase length is a parameter. The defaults assume 0.5 ns per tick.

Top module: `sram_strobe_seq`

## Requirements
- R1: While idle and after reset, busy is low and precharge is high. Write-driver enable, decoder enable, sense enable, capture and done are all low.
- R2: A write accepted at a clock edge starts in the next tick. Precharge is low from that tick onward. Write-driver enable is high for WR_LEAD_T + WL_T ticks. Decoder enable is high for WL_T ticks, starting WR_LEAD_T ticks after the write begins.
- R3: A read starts with RD_PRE_T ticks of precharge. Decoder enable then follows for WL_T ticks. Write-driver enable stays low throughout the read.
- R4: During a read, sense enable rises SA_DLY_T ticks after decoder enable rises. It stays high through the capture ticks and is never high during a write.
- R5: Capture is high for CAP_T ticks. These start on the tick right after decoder enable falls during a read, and the word is sampled during them.
- R6: The trailing precharge lasts WR_REC_T ticks after a write and RD_REC_T ticks after a read. Done is high on the last tick of that precharge only.
- R7: Precharge is never high in the same tick as write-driver enable or decoder enable.
- R8: If read and write are requested together while idle, req_err pulses for one tick. No operation starts and all strobes keep their idle values.
- R9: Busy is high from the first tick to the last tick of an operation. Requests that arrive while busy, including conflicting ones, are ignored and raise no error.
- R10: row_sel holds the address sampled when the request was accepted and does not change until the operation ends.
- R11: A word written to a row with these strobes is read back unchanged from that row by an array that honours them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock; one period is one tick |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request, sampled while idle |
| wr_req | input | 1 | Write request, sampled while idle |
| row_addr | input | 6 | Row to access, sampled with the request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last tick of the current operation |
| req_err | output | 1 | One-tick pulse after a conflicting request |
| pre_en | output | 1 | Bitline precharge enable |
| wde | output | 1 | Write-driver enable |
| dec_en | output | 1 | Row-decoder / wordline enable |
| row_sel | output | 6 | Latched row to the decoder |
| sae | output | 1 | Sense-amplifier enable |
| cap_en | output | 1 | Output-register capture strobe |

## Verification
A wrong phase or a counter off by one shows up at the strobe ports in the very next tick: a strobe edge arrives early or late, or precharge meets an open wordline. The bench compares every strobe on every tick of every operation, so it catches any shift of a single tick. A wrong write/read flag or a badly latched row shows up later, as a corrupted word when the same row is read back through the array model.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_RPRE = 3'd1,
    PH_WDRV = 3'd2,
    PH_ACC  = 3'd3,
    PH_CAPT = 3'd4,
    PH_REC  = 3'd5
  } phase_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Length in ticks of a phase; the idle phase counts as one tick.
  function automatic int unsigned phase_len(
    input phase_e      ph,
    input logic        is_wr,
    input int unsigned rd_pre,
    input int unsigned wr_lead,
    input int unsigned wl,
    input int unsigned cap,
    input int unsigned wr_rec,
    input int unsigned rd_rec
  );
    case (ph)
      PH_RPRE: return rd_pre;
      PH_WDRV: return wr_lead;
      PH_ACC:  return wl;
      PH_CAPT: return cap;
      PH_REC:  return is_wr ? wr_rec : rd_rec;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          zero
);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/sram_seq_strobes.sv
module sram_seq_strobes
  import sram_seq_pkg::*;
#(
  parameter int unsigned CW       = 4,
  parameter int unsigned WL_T     = 4,
  parameter int unsigned SA_DLY_T = 2
) (
  input  phase_e        ph,
  input  logic          is_wr,
  input  logic [CW-1:0] cnt,
  input  logic          cnt_zero,
  output logic          busy,
  output logic          pre_en,
  output logic          wde,
  output logic          dec_en,
  output logic          sae,
  output logic          cap_en,
  output logic          done
);

  // Remaining-count value at which the sense amplifier turns on.
  localparam logic [CW-1:0] SAE_AT = CW'(WL_T - 1 - SA_DLY_T);

  logic in_acc;
  assign in_acc = (ph == PH_ACC);

  always_comb begin
    busy   = (ph != PH_IDLE);
    pre_en = (ph == PH_IDLE) || (ph == PH_RPRE) || (ph == PH_REC);
    wde    = (ph == PH_WDRV) || (in_acc && is_wr);
    dec_en = in_acc;
    cap_en = (ph == PH_CAPT);
    sae    = (in_acc && !is_wr && (cnt <= SAE_AT)) || (ph == PH_CAPT);
    done   = (ph == PH_REC) && cnt_zero;
  end

endmodule

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq
  import sram_seq_pkg::*;
#(
  parameter int unsigned ROWS      = 64,
  parameter int unsigned RD_PRE_T  = 1,
  parameter int unsigned WR_LEAD_T = 1,
  parameter int unsigned WL_T      = 4,
  parameter int unsigned SA_DLY_T  = 2,
  parameter int unsigned CAP_T     = 1,
  parameter int unsigned WR_REC_T  = 8,
  parameter int unsigned RD_REC_T  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_req,
  input  logic                    wr_req,
  input  logic [$clog2(ROWS)-1:0] row_addr,
  output logic                    busy,
  output logic                    done,
  output logic                    req_err,
  output logic                    pre_en,
  output logic                    wde,
  output logic                    dec_en,
  output logic [$clog2(ROWS)-1:0] row_sel,
  output logic                    sae,
  output logic                    cap_en
);

  localparam int unsigned AW   = $clog2(ROWS);
  localparam int unsigned MAXT = max2(max2(max2(RD_PRE_T, WR_LEAD_T), max2(WL_T, CAP_T)),
                                      max2(WR_REC_T, RD_REC_T));
  localparam int unsigned CW   = $clog2(MAXT + 1);

  phase_e          ph_q, ph_nx;
  logic            wr_q, wr_nx;
  logic [AW-1:0]   row_q;
  logic            err_q;
  logic [CW-1:0]   cnt;
  logic            cnt_zero;
  logic            accept_evt;
  logic            conflict_evt;
  logic            phase_end;
  logic            adv;
  logic [CW-1:0]   load_val;

  assign accept_evt   = (ph_q == PH_IDLE) && (rd_req ^ wr_req);
  assign conflict_evt = (ph_q == PH_IDLE) && rd_req && wr_req;
  assign phase_end    = (ph_q != PH_IDLE) && cnt_zero;
  assign adv          = accept_evt || phase_end;
  assign wr_nx        = accept_evt ? wr_req : wr_q;

  always_comb begin
    case (ph_q)
      PH_IDLE: ph_nx = accept_evt ? (wr_req ? PH_WDRV : PH_RPRE) : PH_IDLE;
      PH_RPRE: ph_nx = PH_ACC;
      PH_WDRV: ph_nx = PH_ACC;
      PH_ACC:  ph_nx = wr_q ? PH_REC : PH_CAPT;
      PH_CAPT: ph_nx = PH_REC;
      default: ph_nx = PH_IDLE;
    endcase
  end

  assign load_val = CW'(phase_len(ph_nx, wr_nx, RD_PRE_T, WR_LEAD_T, WL_T,
                                  CAP_T, WR_REC_T, RD_REC_T) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      wr_q  <= 1'b0;
      row_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= conflict_evt;
      if (adv) ph_q <= ph_nx;
      if (accept_evt) begin
        wr_q  <= wr_req;
        row_q <= row_addr;
      end
    end
  end

  sram_seq_timer #(.CW(CW)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (adv),
    .load_val (load_val),
    .cnt      (cnt),
    .zero     (cnt_zero)
  );

  sram_seq_strobes #(.CW(CW), .WL_T(WL_T), .SA_DLY_T(SA_DLY_T)) strobes_i (
    .ph       (ph_q),
    .is_wr    (wr_q),
    .cnt      (cnt),
    .cnt_zero (cnt_zero),
    .busy     (busy),
    .pre_en   (pre_en),
    .wde      (wde),
    .dec_en   (dec_en),
    .sae      (sae),
    .cap_en   (cap_en),
    .done     (done)
  );

  assign row_sel = row_q;
  assign req_err = err_q;

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
  parameter int unsigned AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          req_err,
  input logic          pre_en,
  input logic          wde,
  input logic          dec_en,
  input logic          sae,
  input logic          cap_en,
  input logic [AW-1:0] row_sel,
  input logic          accept_evt
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pre_en && !wde && !dec_en && !sae && !cap_en && !done)); // R1

  AST_NO_SENSE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wde && sae)); // R2

  AST_SAE_AFTER_WL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sae) |-> $past(dec_en)); // R4

  AST_CAP_AFTER_WL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_en) |-> ($past(dec_en) && !dec_en && sae)); // R5

  AST_DONE_IN_REC: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && pre_en)); // R6

  AST_NO_PRE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !(pre_en && (wde || dec_en))); // R7

  AST_ERR_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !busy); // R8

  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |-> !busy); // R9

  AST_ROW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(row_sel)); // R10

endmodule

bind sram_strobe_seq sram_seq_chk #(.AW(AW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .req_err    (req_err),
  .pre_en     (pre_en),
  .wde        (wde),
  .dec_en     (dec_en),
  .sae        (sae),
  .cap_en     (cap_en),
  .row_sel    (row_sel),
  .accept_evt (accept_evt)
);

// File: tb/sram_strobe_seq_tb.sv
module sram_strobe_seq_tb_top;

  localparam int TRP = 1, TLEAD = 1, TWL = 4, TSA = 2, TCAP = 1, TWREC = 8, TRREC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_req = 1'b0, wr_req = 1'b0;
  logic [5:0] row_addr = '0;
  logic busy, done, req_err, pre_en, wde, dec_en, sae, cap_en;
  logic [5:0] row_sel;

  logic [31:0] wdata_m = '0;
  logic [31:0] rdata_m;
  logic [31:0] mem [64];

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  sram_strobe_seq dut_i (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req), .row_addr(row_addr),
    .busy(busy), .done(done), .req_err(req_err), .pre_en(pre_en), .wde(wde),
    .dec_en(dec_en), .row_sel(row_sel), .sae(sae), .cap_en(cap_en)
  );

  // Behavioural array: stores only under an open wordline with drivers on,
  // delivers a word only when sensing is on at capture.
  always @(posedge clk) begin
    if (dec_en && wde && !pre_en) mem[row_sel] <= wdata_m;
    if (cap_en && sae) rdata_m <= mem[row_sel];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // {busy, pre, wde, dec, sae, cap, done} expected on tick k of an operation
  function automatic logic [6:0] expv(input bit w, input int k);
    logic b, p, d, e, s, c, n;
    int total;
    b = 1; p = 0; d = 0; e = 0; s = 0; c = 0; n = 0;
    if (w) begin
      total = TLEAD + TWL + TWREC;
      if (k < TLEAD) d = 1;
      else if (k < TLEAD + TWL) begin d = 1; e = 1; end
      else begin p = 1; n = (k == total - 1); end
    end else begin
      total = TRP + TWL + TCAP + TRREC;
      if (k < TRP) p = 1;
      else if (k < TRP + TWL) begin e = 1; s = (k - TRP >= TSA); end
      else if (k < TRP + TWL + TCAP) begin c = 1; s = 1; end
      else begin p = 1; n = (k == total - 1); end
    end
    return {b, p, d, e, s, c, n};
  endfunction

  task automatic check_idle(input string tag);
    chk(!busy && pre_en && !wde && !dec_en && !sae && !cap_en && !done, tag,
        {25'd0, busy, pre_en, wde, dec_en, sae, cap_en, done}, 32'h20);
  endtask

  // One operation; if poke is set, a conflicting request and a new row arrive mid-way.
  task automatic run_op(input bit w, input logic [5:0] row, input logic [31:0] data, input bit poke);
    int total;
    logic [6:0] ev;
    string tg;
    total = w ? (TLEAD + TWL + TWREC) : (TRP + TWL + TCAP + TRREC);
    tg = w ? "R2" : "R3";
    @(negedge clk);
    wr_req = w; rd_req = !w; row_addr = row; wdata_m = data;
    @(posedge clk);
    for (int k = 0; k < total; k++) begin
      @(negedge clk);
      if (k == 0) begin wr_req = 0; rd_req = 0; end
      if (poke && k == 3) begin wr_req = 1; rd_req = 1; row_addr = ~row; end
      if (poke && k == 5) begin wr_req = 0; rd_req = 0; end
      ev = expv(w, k);
      chk(busy == ev[6], "R9", {31'd0, busy}, {31'd0, ev[6]});
      chk(pre_en == ev[5], tg, {31'd0, pre_en}, {31'd0, ev[5]});
      chk(wde == ev[4], tg, {31'd0, wde}, {31'd0, ev[4]});
      chk(dec_en == ev[3], tg, {31'd0, dec_en}, {31'd0, ev[3]});
      chk(sae == ev[2], "R4", {31'd0, sae}, {31'd0, ev[2]});
      chk(cap_en == ev[1], "R5", {31'd0, cap_en}, {31'd0, ev[1]});
      chk(done == ev[0], "R6", {31'd0, done}, {31'd0, ev[0]});
      chk(!(pre_en && (wde || dec_en)), "R7", {30'd0, pre_en, wde | dec_en}, 32'd0);
      chk(row_sel == row, "R10", {26'd0, row_sel}, {26'd0, row});
      if (poke) chk(!req_err, "R9", {31'd0, req_err}, 32'd0);
    end
    @(negedge clk);
    check_idle(poke ? "R9" : "R1");
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle("R1");
    chk(!req_err, "R1", {31'd0, req_err}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check_idle("R1");
  endtask

  task automatic t_roundtrip(input logic [5:0] row, input logic [31:0] data);
    run_op(1'b1, row, data, 1'b0);
    run_op(1'b0, row, 32'd0, 1'b0);
    chk(rdata_m == data, "R11", rdata_m, data);
  endtask

  task automatic t_conflict();
    @(negedge clk);
    rd_req = 1; wr_req = 1; row_addr = 6'd9;
    @(negedge clk);
    chk(req_err, "R8", {31'd0, req_err}, 32'd1);
    check_idle("R8");
    rd_req = 0; wr_req = 0;
    @(negedge clk);
    chk(!req_err, "R8", {31'd0, req_err}, 32'd0);
    check_idle("R8");
  endtask

  task automatic t_busy_ignore();
    run_op(1'b0, 6'd63, 32'd0, 1'b1);
    chk(rdata_m == 32'hFFFF_0000, "R11", rdata_m, 32'hFFFF_0000);
    @(negedge clk);
    check_idle("R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_roundtrip(6'd0, 32'h0000_0000);
    t_roundtrip(6'd21, 32'hA5C3_0F96);
    t_roundtrip(6'd63, 32'hFFFF_0000);
    run_op(1'b1, 6'd1, 32'h1234_5678, 1'b0);
    run_op(1'b1, 6'd2, 32'h8765_4321, 1'b0);
    run_op(1'b0, 6'd1, 32'd0, 1'b0);
    chk(rdata_m == 32'h1234_5678, "R11", rdata_m, 32'h1234_5678);
    run_op(1'b0, 6'd2, 32'd0, 1'b0);
    chk(rdata_m == 32'h8765_4321, "R11", rdata_m, 32'h8765_4321);
    t_conflict();
    t_busy_ignore();
    run_op(1'b1, 6'd40, 32'hDEAD_BEEF, 1'b1);
    run_op(1'b0, 6'd40, 32'd0, 1'b0);
    chk(rdata_m == 32'hDEAD_BEEF, "R11", rdata_m, 32'hDEAD_BEEF);
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule